// File: doc/BRIEF.md
# Broadcast Buffer Throttle

This block decides, frame by frame, whether a newly received broadcast frame may claim a packet buffer. It keeps one counter per source port that holds the number of buffers currently occupied by broadcast frames from that port. It also watches the shared pool: global occupancy is derived from the pool's free-buffer count and compared with a congestion threshold. A broadcast frame is dropped when its own port has used up its broadcast allowance or when the pool as a whole is too loaded. Frames that are not broadcast are always admitted and leave the counters alone.

The per-port allowances are captured once, by a load strobe after reset, and then stay fixed until the next reset. A small controller has two states. `ST_CFG_WAIT` is entered on reset; in it no allowance is known yet, so every broadcast is dropped. The transition `CFG_LOAD` fires on the first load strobe, captures the allowances and moves to `ST_ACTIVE`. `ST_ACTIVE` holds until reset, and later strobes are ignored. Each request gets a registered decision one cycle later. The buffer manager reports each buffer it frees through a release event, and a release that belongs to a broadcast frame lowers the count for its port.

Top module: `bcast_throttle`

## Requirements
- R1: After reset `cfg_done` and `dec_valid` are 0. While `cfg_done` is 0, every broadcast request is dropped (`dec_admit`=0).
- R2: The first `cfg_valid` pulse after reset captures `cfg_caps` (port p's allowance is bits [4p+3:4p] with the default width of 4). `cfg_done` reads 1 from the next cycle on. Later pulses change neither `cfg_done` nor the allowances.
- R3: A request in cycle t gives `dec_valid`=1 in cycle t+1, with `dec_port` and `dec_bcast` equal to the request's port and broadcast flag. `dec_valid` is 0 in a cycle that follows no request.
- R4: A request with `req_bcast`=0 is always admitted, whatever the occupancy or counts. It does not change any port's count.
- R5: A broadcast request is admitted when its port's count is below that port's allowance and occupancy (`NUM_BUFS` − `pool_free`, or 0 if `pool_free` ≥ `NUM_BUFS`) is below `cong_thr`. Admission raises that port's count by one.
- R6: A broadcast request whose port's count equals its allowance is dropped and the count is unchanged. An allowance of 0 drops every broadcast from that port.
- R7: A broadcast request is dropped when occupancy ≥ `cong_thr` (the boundary value itself drops). Its count is unchanged.
- R8: A release with `rel_bcast`=1 lowers `rel_port`'s count by one. At a count of 0 it has no effect, so the count never wraps. A release with `rel_bcast`=0 has no effect.
- R9: An admitted broadcast and a broadcast release for the same port in the same cycle leave that port's count unchanged.
- R10: Each port's count and allowance affect only that port's decisions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_valid | input | 1 | Allowance load strobe, honoured once after reset |
| cfg_caps | input | NUM_PORTS*CAP_W | Per-port broadcast allowances, port 0 in the low bits |
| req_valid | input | 1 | A received frame asks for a buffer |
| req_port | input | PORT_W | Source port of the request |
| req_bcast | input | 1 | The requesting frame is broadcast |
| rel_valid | input | 1 | A buffer is being freed |
| rel_port | input | PORT_W | Source port of the freed buffer's frame |
| rel_bcast | input | 1 | The freed buffer held a broadcast frame |
| pool_free | input | POOL_W | Free buffers in the shared pool |
| cong_thr | input | POOL_W | Occupancy at or above which broadcasts are dropped |
| cfg_done | output | 1 | Controller is in `ST_ACTIVE` |
| dec_valid | output | 1 | Decision valid this cycle |
| dec_port | output | PORT_W | Port of the decided request |
| dec_bcast | output | 1 | Decided request was broadcast |
| dec_admit | output | 1 | 1 = take a buffer, 0 = drop |

## Verification
The two functions that can meet in one cycle are admission, which raises a port's count, and release, which lowers it. The bench provokes this by driving a broadcast request and a broadcast release for the same port in the same vector. It then judges the result at the ports only, issuing exactly as many further broadcasts as the allowance should still permit. The first broadcast past that point must be dropped, and any other outcome shows the count was moved. The same approach covers a release that meets a count of 0: the next requests show whether the count wrapped. It also covers a release that meets a request refused at the allowance: the next request must then be admitted.

// File: rtl/bcast_throttle_pkg.sv
package bcast_throttle_pkg;

    typedef enum logic [0:0] {
        ST_CFG_WAIT = 1'b0,
        ST_ACTIVE   = 1'b1
    } bt_state_e;

    typedef struct packed {
        logic valid;
        logic bcast;
        logic admit;
    } bt_dec_t;

endpackage

// File: rtl/bt_cfg_fsm.sv
module bt_cfg_fsm
    import bcast_throttle_pkg::*;
#(
    parameter int NUM_PORTS = 8,
    parameter int CAP_W     = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       cfg_valid,
    input  logic [NUM_PORTS*CAP_W-1:0] cfg_caps,
    output logic                       active,
    output logic [NUM_PORTS*CAP_W-1:0] caps_q
);
    localparam int CAPS_W = NUM_PORTS * CAP_W;

    bt_state_e state_q, state_d;
    logic      cap_load;

    // next-state logic
    always_comb begin
        state_d  = state_q;
        cap_load = 1'b0;
        unique case (state_q)
            ST_CFG_WAIT: begin
                if (cfg_valid) begin
                    state_d  = ST_ACTIVE;   // transition CFG_LOAD
                    cap_load = 1'b1;
                end
            end
            ST_ACTIVE: begin
                state_d = ST_ACTIVE;
            end
            default: state_d = ST_CFG_WAIT;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_CFG_WAIT;
        end else begin
            state_q <= state_d;
        end
    end

    // allowance storage, written only on CFG_LOAD
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            caps_q <= {CAPS_W{1'b0}};
        end else if (cap_load) begin
            caps_q <= cfg_caps;
        end
    end

    // outputs
    always_comb begin
        unique case (state_q)
            ST_CFG_WAIT: active = 1'b0;
            ST_ACTIVE:   active = 1'b1;
            default:     active = 1'b0;
        endcase
    end

endmodule

// File: rtl/bt_port_counter.sv
module bt_port_counter #(
    parameter int CAP_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc,
    input  logic             dec,
    output logic [CAP_W-1:0] count
);
    localparam logic [CAP_W-1:0] ONE  = {{(CAP_W-1){1'b0}}, 1'b1};
    localparam logic [CAP_W-1:0] ZERO = {CAP_W{1'b0}};

    logic [CAP_W-1:0] count_d;

    always_comb begin
        count_d = count;
        unique case ({inc, dec})
            2'b10:   count_d = count + ONE;
            2'b01:   count_d = (count == ZERO) ? ZERO : count - ONE;
            2'b11:   count_d = count;      // admit and release cancel
            default: count_d = count;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= ZERO;
        end else begin
            count <= count_d;
        end
    end

endmodule

// File: rtl/bt_admit_logic.sv
module bt_admit_logic #(
    parameter int CAP_W    = 4,
    parameter int POOL_W   = 10,
    parameter int NUM_BUFS = 512
) (
    input  logic              active,
    input  logic              bcast,
    input  logic [CAP_W-1:0]  count,
    input  logic [CAP_W-1:0]  cap,
    input  logic [POOL_W-1:0] pool_free,
    input  logic [POOL_W-1:0] cong_thr,
    output logic              congested,
    output logic              admit
);
    localparam int              OCC_W = POOL_W + 1;
    localparam logic [OCC_W-1:0] TOTAL = OCC_W'(NUM_BUFS);

    logic [OCC_W-1:0] free_ext;
    logic [OCC_W-1:0] occupancy;
    logic             port_room;

    always_comb begin
        free_ext  = {1'b0, pool_free};
        occupancy = (free_ext >= TOTAL) ? '0 : (TOTAL - free_ext);
        congested = (occupancy >= {1'b0, cong_thr});
        port_room = (count < cap);
        if (!bcast) begin
            admit = 1'b1;
        end else begin
            admit = active && port_room && !congested;
        end
    end

endmodule

// File: rtl/bcast_throttle.sv
module bcast_throttle
    import bcast_throttle_pkg::*;
#(
    parameter int NUM_PORTS = 8,
    parameter int CAP_W     = 4,
    parameter int POOL_W    = 10,
    parameter int NUM_BUFS  = 512,
    localparam int PORT_W   = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       cfg_valid,
    input  logic [NUM_PORTS*CAP_W-1:0] cfg_caps,
    input  logic                       req_valid,
    input  logic [PORT_W-1:0]          req_port,
    input  logic                       req_bcast,
    input  logic                       rel_valid,
    input  logic [PORT_W-1:0]          rel_port,
    input  logic                       rel_bcast,
    input  logic [POOL_W-1:0]          pool_free,
    input  logic [POOL_W-1:0]          cong_thr,
    output logic                       cfg_done,
    output logic                       dec_valid,
    output logic [PORT_W-1:0]          dec_port,
    output logic                       dec_bcast,
    output logic                       dec_admit
);
    localparam int CAPS_W = NUM_PORTS * CAP_W;

    logic [CAPS_W-1:0] caps_q;
    logic [CAP_W-1:0]  cnt   [NUM_PORTS];
    logic [CAP_W-1:0]  cnt_sel;
    logic [CAP_W-1:0]  cap_sel;
    logic              admit_now;
    logic              cong_now;
    bt_dec_t           dec_d, dec_q;
    logic [PORT_W-1:0] port_q;

    bt_cfg_fsm #(
        .NUM_PORTS (NUM_PORTS),
        .CAP_W     (CAP_W)
    ) u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_valid (cfg_valid),
        .cfg_caps  (cfg_caps),
        .active    (cfg_done),
        .caps_q    (caps_q)
    );

    generate
        for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
            logic inc_p, dec_p;
            assign inc_p = req_valid && req_bcast && admit_now
                           && (req_port == PORT_W'(p));
            assign dec_p = rel_valid && rel_bcast
                           && (rel_port == PORT_W'(p));
            bt_port_counter #(
                .CAP_W (CAP_W)
            ) u_cnt (
                .clk   (clk),
                .rst_n (rst_n),
                .inc   (inc_p),
                .dec   (dec_p),
                .count (cnt[p])
            );
        end
    endgenerate

    always_comb begin
        cnt_sel = '0;
        cap_sel = '0;
        for (int p = 0; p < NUM_PORTS; p++) begin
            if (req_port == PORT_W'(p)) begin
                cnt_sel = cnt[p];
                cap_sel = caps_q[p*CAP_W +: CAP_W];
            end
        end
    end

    bt_admit_logic #(
        .CAP_W    (CAP_W),
        .POOL_W   (POOL_W),
        .NUM_BUFS (NUM_BUFS)
    ) u_adm (
        .active    (cfg_done),
        .bcast     (req_bcast),
        .count     (cnt_sel),
        .cap       (cap_sel),
        .pool_free (pool_free),
        .cong_thr  (cong_thr),
        .congested (cong_now),
        .admit     (admit_now)
    );

    always_comb begin
        dec_d.valid = req_valid;
        dec_d.bcast = req_bcast;
        dec_d.admit = req_valid && admit_now;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dec_q  <= '0;
            port_q <= '0;
        end else begin
            dec_q  <= dec_d;
            port_q <= req_port;
        end
    end

    assign dec_valid = dec_q.valid;
    assign dec_bcast = dec_q.bcast;
    assign dec_admit = dec_q.admit;
    assign dec_port  = port_q;

endmodule

// File: rtl/bcast_throttle_chk.sv
module bcast_throttle_chk (
    input logic clk,
    input logic rst_n,
    input logic req_valid,
    input logic req_bcast,
    input logic cong,
    input logic cfg_done,
    input logic dec_valid,
    input logic dec_bcast,
    input logic dec_admit
);
    AST_DEC_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> dec_valid);                                   // R3
    AST_DEC_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !dec_valid);                                 // R3
    AST_UNICAST_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid && !dec_bcast) |-> dec_admit);                   // R4
    AST_CFG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_done |=> cfg_done);                                     // R2
    AST_NOCFG_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_bcast && !cfg_done) |=> !dec_admit);      // R1
    AST_CONGEST_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_bcast && cong) |=> !dec_admit);           // R7
endmodule

bind bcast_throttle bcast_throttle_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_bcast (req_bcast),
    .cong      (cong_now),
    .cfg_done  (cfg_done),
    .dec_valid (dec_valid),
    .dec_bcast (dec_bcast),
    .dec_admit (dec_admit)
);

// File: tb/bcast_throttle_test.sv
module bcast_throttle_test;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        cfg_valid;
    logic [31:0] cfg_caps;
    logic        req_valid;
    logic [2:0]  req_port;
    logic        req_bcast;
    logic        rel_valid;
    logic [2:0]  rel_port;
    logic        rel_bcast;
    logic [9:0]  pool_free;
    logic [9:0]  cong_thr;
    logic        cfg_done, dec_valid, dec_bcast, dec_admit;
    logic [2:0]  dec_port;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    always #5 clk = ~clk;

    bcast_throttle uut (
        .clk(clk), .rst_n(rst_n), .cfg_valid(cfg_valid), .cfg_caps(cfg_caps),
        .req_valid(req_valid), .req_port(req_port), .req_bcast(req_bcast),
        .rel_valid(rel_valid), .rel_port(rel_port), .rel_bcast(rel_bcast),
        .pool_free(pool_free), .cong_thr(cong_thr), .cfg_done(cfg_done),
        .dec_valid(dec_valid), .dec_port(dec_port), .dec_bcast(dec_bcast),
        .dec_admit(dec_admit)
    );

    typedef struct packed {
        logic       bc;
        logic [2:0] port;
        logic       rel;
        logic [2:0] rport;
        logic       rbc;
        logic [9:0] free;
        logic       exp;
    } vec_t;

    // allowances: p0=2 p1=1 p2=0 others=3; threshold 400 of 512 buffers
    localparam int NV = 20;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 3'd0, 1'b0, 3'd0, 1'b0, 10'd500, 1'b1}, // R5 p0 ->1
        '{1'b1, 3'd0, 1'b0, 3'd0, 1'b0, 10'd500, 1'b1}, // R5 p0 ->2
        '{1'b1, 3'd0, 1'b0, 3'd0, 1'b0, 10'd500, 1'b0}, // R6 p0 at allowance
        '{1'b0, 3'd0, 1'b0, 3'd0, 1'b0, 10'd500, 1'b1}, // R4 unicast
        '{1'b1, 3'd1, 1'b0, 3'd0, 1'b0, 10'd500, 1'b1}, // R5 p1 ->1
        '{1'b1, 3'd1, 1'b0, 3'd0, 1'b0, 10'd500, 1'b0}, // R6 p1 full
        '{1'b1, 3'd2, 1'b0, 3'd0, 1'b0, 10'd500, 1'b0}, // R6 allowance 0
        '{1'b1, 3'd3, 1'b0, 3'd0, 1'b0, 10'd112, 1'b0}, // R7 occ=400
        '{1'b1, 3'd3, 1'b0, 3'd0, 1'b0, 10'd113, 1'b1}, // R7 occ=399, p3 ->1
        '{1'b0, 3'd3, 1'b0, 3'd0, 1'b0, 10'd0,   1'b1}, // R4 unicast congested
        '{1'b1, 3'd0, 1'b1, 3'd0, 1'b1, 10'd500, 1'b0}, // R8 p0 full, released ->1
        '{1'b1, 3'd0, 1'b0, 3'd0, 1'b0, 10'd500, 1'b1}, // R8 p0 ->2
        '{1'b1, 3'd1, 1'b1, 3'd1, 1'b0, 10'd500, 1'b0}, // R8 non-bcast release ignored
        '{1'b1, 3'd4, 1'b1, 3'd5, 1'b1, 10'd500, 1'b1}, // R8 release at zero, p4 ->1
        '{1'b1, 3'd5, 1'b0, 3'd0, 1'b0, 10'd500, 1'b1}, // R8 p5 not wrapped ->1
        '{1'b1, 3'd3, 1'b1, 3'd3, 1'b1, 10'd500, 1'b1}, // R9 cancel, p3 stays 1
        '{1'b1, 3'd3, 1'b0, 3'd0, 1'b0, 10'd500, 1'b1}, // R9 p3 ->2
        '{1'b1, 3'd3, 1'b0, 3'd0, 1'b0, 10'd500, 1'b1}, // R9 p3 ->3
        '{1'b1, 3'd3, 1'b0, 3'd0, 1'b0, 10'd500, 1'b0}, // R9 p3 full
        '{1'b1, 3'd6, 1'b0, 3'd0, 1'b0, 10'd500, 1'b1}  // R10 p6 independent
    };

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic idle();
        req_valid = 0; req_port = 0; req_bcast = 0;
        rel_valid = 0; rel_port = 0; rel_bcast = 0;
        cfg_valid = 0;
    endtask

    task automatic request(input logic bc, input logic [2:0] p);
        req_valid = 1; req_bcast = bc; req_port = p;
        @(negedge clk);
        idle();
    endtask

    initial begin
        rst_n = 0;
        idle();
        cfg_caps  = {4'd3, 4'd3, 4'd3, 4'd3, 4'd3, 4'd0, 4'd1, 4'd2};
        cong_thr  = 10'd400;
        pool_free = 10'd500;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        check("R1 cfg_done after reset", cfg_done, 0);
        check("R1 dec_valid after reset", dec_valid, 0);

        request(1'b1, 3'd3);
        check("R1 broadcast before load dropped", dec_admit, 0);
        request(1'b0, 3'd3);
        check("R4 unicast before load admitted", dec_admit, 1);
        check("R3 dec_valid after request", dec_valid, 1);

        cfg_valid = 1;
        @(negedge clk);
        cfg_valid = 0;
        check("R2 cfg_done after load", cfg_done, 1);

        for (int i = 0; i < NV; i++) begin
            req_valid = 1; req_bcast = VECS[i].bc; req_port = VECS[i].port;
            rel_valid = VECS[i].rel; rel_port = VECS[i].rport;
            rel_bcast = VECS[i].rbc; pool_free = VECS[i].free;
            @(negedge clk);
            idle();
            pool_free = 10'd500;
            check($sformatf("R5-table vector %0d admit", i), dec_admit, VECS[i].exp);
            check($sformatf("R3 vector %0d port/bcast/valid", i),
                  {dec_valid, dec_port, dec_bcast}, {1'b1, VECS[i].port, VECS[i].bc});
        end

        @(negedge clk);
        check("R3 dec_valid drops when idle", dec_valid, 0);

        cfg_caps  = {8{4'd15}};
        cfg_valid = 1;
        @(negedge clk);
        cfg_valid = 0;
        request(1'b1, 3'd1);
        check("R2 later load ignored, p1 still full", dec_admit, 0);
        check("R2 cfg_done stays", cfg_done, 1);
        request(1'b1, 3'd7);
        check("R10 p7 admitted", dec_admit, 1);
        done = 1;
    end

    initial begin : watchdog
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                checks++;
                errors++;
                $display("FAIL watchdog actual 0 expected 1");
            end
        join_any
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule